// File: doc/BRIEF.md
# Embedded Operation Polling Status Generator

This block forms the status word that a parallel flash device places on its data bus while the internal program/erase engine is running, while an erase is suspended, or after an operation has failed or a buffered program has been aborted. The engine supplies its state: busy, erase or program, suspended, a failure pulse, an abort pulse, and whether the block-erase accumulation window is still open. It also supplies the polling bit of the data being programmed, the block under operation and the suspended block. The read path supplies the block field of the read address and the output-enable strobe. The block raises `statusActive` whenever the status word must replace array data on the bus.

The word changes from one read to the next. Two bits flip on every read access, and one of them flips only when the read address falls in the block concerned. Each read access is one falling edge of the active-low output enable. That edge is detected synchronously, so one read advances the toggles once, however long the strobe stays low. Failure and abort indications are kept until the matching reset command arrives.

Top module: `flash_poll_status`

## Requirements
- R1: While `engBusy` is 1, `statusActive` is 1 for every value of `rdBlock`. With no engine activity, no latched failure or abort, and no suspended-block hit, `statusActive` is 0 and `statusWord` is all zeros.
- R2: While a program is busy (`engIsErase`=0), bit 7 of `statusWord` is the complement of `progPollBit`.
- R3: While an erase is busy, bit 7 reads 0. In suspend status (suspended, not busy, read in the suspended block), bit 7 reads 1.
- R4: Bit 6 inverts once for each falling edge of `oeN` seen while the engine is busy or a failure or abort is latched. A strobe held low for several clocks gives one inversion. In every other state bit 6 holds its value.
- R5: A pulse on `engFail` sets bit 5 from the next cycle. The status word, with bit 7 taken from the operation captured before the failure, stays on the bus after `engBusy` falls, until a pulse on `cmdReadReset`.
- R6: A pulse on `bufAbort` sets bit 1 and keeps the status word active until a pulse on `cmdAbortReset`. A `cmdReadReset` pulse does not clear it.
- R7: While an erase is busy, bit 3 is 0 when `eraseWindowOpen` is 1 and is 1 otherwise. While a program is busy, bit 3 is 0.
- R8: While erase is suspended and the engine is idle, a read whose `rdBlock` equals `suspBlock` returns status and inverts bit 2 once per read. A read of any other block gives `statusActive`=0 and leaves bit 2 unchanged.
- R9: While an erase is busy, bit 2 inverts on reads whose `rdBlock` equals `opBlock` and holds on reads of other blocks. During a program, bit 2 holds.
- R10: When `engBusy` falls with no failure or abort latched, `statusActive` drops in the same cycle.
- R11: Bits 0 and 4, and every bit above bit 7, always read 0.
- R12: After reset, both toggle bits are 0, no failure or abort is latched, and the outputs are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| oeN | input | 1 | Active-low output enable; each falling edge is one read access |
| rdBlock | input | BLK_W | Block field of the read address |
| engBusy | input | 1 | Embedded operation in progress |
| engIsErase | input | 1 | 1 = the operation is an erase, 0 = a program |
| engSuspended | input | 1 | Erase is suspended |
| engFail | input | 1 | One-cycle pulse: the operation failed |
| bufAbort | input | 1 | One-cycle pulse: the buffered program was aborted |
| eraseWindowOpen | input | 1 | Block-erase accumulation window still open |
| progPollBit | input | 1 | Bit 7 of the data being programmed |
| opBlock | input | BLK_W | Block under operation |
| suspBlock | input | BLK_W | Block whose erase is suspended |
| cmdReadReset | input | 1 | One-cycle pulse: read/reset command decoded |
| cmdAbortReset | input | 1 | One-cycle pulse: abort-and-reset sequence decoded |
| statusActive | output | 1 | Status word replaces array data |
| statusWord | output | DATA_W | Polling status word |

## Verification
The embedded properties check on every cycle that a busy engine always forces status onto the bus, that the failure and abort indications survive until their own reset command, that bit 6 changes exactly on the cycles the control marks as read accesses, and that the unused bit positions stay zero. What only the scenarios can show is the content of each read. That covers the polarity of bit 7 against the programmed data, the exact sequence of bit 6 and bit 2 across a series of reads, and a low strobe held for many clocks counting once. It also covers the address test that decides whether bit 2 moves and whether a read during suspend sees status or array data at all. The bench tracks a model of the toggles and flags, built from the requirements, through random mixes of engine states, addresses and commands.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  // What the bus carries at the current read
  typedef enum logic [2:0] {
    MODE_ARRAY = 3'd0,
    MODE_BUSY  = 3'd1,
    MODE_SUSP  = 3'd2,
    MODE_FAIL  = 3'd3,
    MODE_ABORT = 3'd4
  } pollMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    pollMode_e mode;
    logic      adv6;     // advance the per-read toggle
    logic      adv2;     // advance the block-qualified toggle
    logic      capture;  // remember the running operation
    logic      failOn;
    logic      abortOn;
  } pollStrobe_t;

  // Bit positions inside the status word
  localparam int unsigned BIT_POLL   = 7;
  localparam int unsigned BIT_TOGGLE = 6;
  localparam int unsigned BIT_FAIL   = 5;
  localparam int unsigned BIT_ERSTRT = 3;
  localparam int unsigned BIT_BLKTOG = 2;
  localparam int unsigned BIT_ABORT  = 1;

endpackage

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        oeN,
  input  logic        engBusy,
  input  logic        engIsErase,
  input  logic        engSuspended,
  input  logic        engFail,
  input  logic        bufAbort,
  input  logic        cmdReadReset,
  input  logic        cmdAbortReset,
  input  logic        hitOp,
  input  logic        hitSusp,
  output pollStrobe_t strb
);

  logic oePrev;
  logic failFlag;
  logic abortFlag;
  logic readFall;
  pollMode_e mode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oePrev    <= 1'b1;
      failFlag  <= 1'b0;
      abortFlag <= 1'b0;
    end else begin
      oePrev    <= oeN;
      failFlag  <= engFail  | (failFlag  & ~cmdReadReset);
      abortFlag <= bufAbort | (abortFlag & ~cmdAbortReset);
    end
  end

  assign readFall = oePrev & ~oeN;

  // Priority: failure, abort, running engine, suspended-block hit
  always_comb begin
    if (failFlag)                     mode = MODE_FAIL;
    else if (abortFlag)               mode = MODE_ABORT;
    else if (engBusy)                 mode = MODE_BUSY;
    else if (engSuspended && hitSusp) mode = MODE_SUSP;
    else                              mode = MODE_ARRAY;
  end

  always_comb begin
    strb.mode    = mode;
    strb.failOn  = failFlag;
    strb.abortOn = abortFlag;
    strb.capture = engBusy & ~failFlag;
    strb.adv6    = readFall & ((mode == MODE_BUSY) | (mode == MODE_FAIL) |
                               (mode == MODE_ABORT));
    strb.adv2    = readFall & ((mode == MODE_SUSP) |
                               ((mode == MODE_BUSY) & engIsErase & hitOp));
  end

  // R5
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !cmdReadReset) |=> failFlag);

  // R6
  abort_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abortFlag && !cmdAbortReset) |=> abortFlag);

  // R4
  one_advance_per_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.adv6 |=> !strb.adv6);

endmodule

// File: rtl/flash_poll_datapath.sv
module flash_poll_datapath
  import flash_poll_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BLK_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobe_t       strb,
  input  logic [BLK_W-1:0]  rdBlock,
  input  logic [BLK_W-1:0]  opBlock,
  input  logic [BLK_W-1:0]  suspBlock,
  input  logic              engIsErase,
  input  logic              eraseWindowOpen,
  input  logic              progPollBit,
  output logic              hitOp,
  output logic              hitSusp,
  output logic [DATA_W-1:0] statusWord
);

  logic tog6q;
  logic tog2q;
  logic capErase;
  logic capPoll;
  logic pollBit;
  logic eraseStarted;

  assign hitOp   = (rdBlock == opBlock);
  assign hitSusp = (rdBlock == suspBlock);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tog6q    <= 1'b0;
      tog2q    <= 1'b0;
      capErase <= 1'b0;
      capPoll  <= 1'b0;
    end else begin
      if (strb.adv6)    tog6q <= ~tog6q;
      if (strb.adv2)    tog2q <= ~tog2q;
      if (strb.capture) begin
        capErase <= engIsErase;
        capPoll  <= progPollBit;
      end
    end
  end

  always_comb begin
    unique case (strb.mode)
      MODE_BUSY:              pollBit = engIsErase ? 1'b0 : ~progPollBit;
      MODE_SUSP:              pollBit = 1'b1;
      MODE_FAIL, MODE_ABORT:  pollBit = capErase ? 1'b0 : ~capPoll;
      default:                pollBit = 1'b0;
    endcase
  end

  assign eraseStarted = (strb.mode == MODE_BUSY) & engIsErase & ~eraseWindowOpen;

  always_comb begin
    statusWord = '0;
    if (strb.mode != MODE_ARRAY) begin
      statusWord[BIT_POLL]   = pollBit;
      statusWord[BIT_TOGGLE] = tog6q;
      statusWord[BIT_FAIL]   = strb.failOn;
      statusWord[BIT_ERSTRT] = eraseStarted;
      statusWord[BIT_BLKTOG] = tog2q;
      statusWord[BIT_ABORT]  = strb.abortOn;
    end
  end

  // R4
  toggle_moves_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.adv6 |=> (tog6q != $past(tog6q)));

  // R4
  toggle_holds_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.adv6 |=> $stable(tog6q));

  // R8
  blk_toggle_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.adv2 |=> $stable(tog2q));

endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
  import flash_poll_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BLK_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oeN,
  input  logic [BLK_W-1:0]  rdBlock,
  input  logic              engBusy,
  input  logic              engIsErase,
  input  logic              engSuspended,
  input  logic              engFail,
  input  logic              bufAbort,
  input  logic              eraseWindowOpen,
  input  logic              progPollBit,
  input  logic [BLK_W-1:0]  opBlock,
  input  logic [BLK_W-1:0]  suspBlock,
  input  logic              cmdReadReset,
  input  logic              cmdAbortReset,
  output logic              statusActive,
  output logic [DATA_W-1:0] statusWord
);

  pollStrobe_t strb;
  logic hitOp;
  logic hitSusp;

  flash_poll_ctrl uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .oeN           (oeN),
    .engBusy       (engBusy),
    .engIsErase    (engIsErase),
    .engSuspended  (engSuspended),
    .engFail       (engFail),
    .bufAbort      (bufAbort),
    .cmdReadReset  (cmdReadReset),
    .cmdAbortReset (cmdAbortReset),
    .hitOp         (hitOp),
    .hitSusp       (hitSusp),
    .strb          (strb)
  );

  flash_poll_datapath #(
    .DATA_W (DATA_W),
    .BLK_W  (BLK_W)
  ) uData (
    .clk             (clk),
    .rstN            (rstN),
    .strb            (strb),
    .rdBlock         (rdBlock),
    .opBlock         (opBlock),
    .suspBlock       (suspBlock),
    .engIsErase      (engIsErase),
    .eraseWindowOpen (eraseWindowOpen),
    .progPollBit     (progPollBit),
    .hitOp           (hitOp),
    .hitSusp         (hitSusp),
    .statusWord      (statusWord)
  );

  assign statusActive = (strb.mode != MODE_ARRAY);

  // R1
  busy_forces_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    engBusy |-> statusActive);

  // R11
  spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[0] && !statusWord[4] && ((statusWord >> 8) == '0));

  // R3
  susp_poll_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mode == MODE_SUSP) |-> statusWord[BIT_POLL]);

endmodule

// File: tb/tb_flash_poll_status.sv
module tb_flash_poll_status;

  localparam int DATA_W = 16;
  localparam int BLK_W  = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oeN = 1'b1;
  logic [BLK_W-1:0] rdBlock = '0;
  logic engBusy = 0, engIsErase = 0, engSuspended = 0, engFail = 0, bufAbort = 0;
  logic eraseWindowOpen = 0, progPollBit = 0, cmdReadReset = 0, cmdAbortReset = 0;
  logic [BLK_W-1:0] opBlock = 7'd1;
  logic [BLK_W-1:0] suspBlock = 7'd2;
  logic statusActive;
  logic [DATA_W-1:0] statusWord;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // model state
  bit mFail, mAbort, mCapErase, mCapPoll, mT6, mT2, mOePrev;

  always #5 clk = ~clk;

  flash_poll_status #(.DATA_W(DATA_W), .BLK_W(BLK_W)) dut (
    .clk(clk), .rstN(rstN), .oeN(oeN), .rdBlock(rdBlock), .engBusy(engBusy),
    .engIsErase(engIsErase), .engSuspended(engSuspended), .engFail(engFail),
    .bufAbort(bufAbort), .eraseWindowOpen(eraseWindowOpen), .progPollBit(progPollBit),
    .opBlock(opBlock), .suspBlock(suspBlock), .cmdReadReset(cmdReadReset),
    .cmdAbortReset(cmdAbortReset), .statusActive(statusActive), .statusWord(statusWord)
  );

  // 0 array, 1 busy, 2 suspend hit, 3 fail, 4 abort
  function automatic int expMode();
    if (mFail)  return 3;
    if (mAbort) return 4;
    if (engBusy) return 1;
    if (engSuspended && rdBlock == suspBlock) return 2;
    return 0;
  endfunction

  function automatic logic [DATA_W-1:0] expWord();
    logic [DATA_W-1:0] w = '0;
    int m = expMode();
    if (m != 0) begin
      case (m)
        1: w[7] = engIsErase ? 1'b0 : ~progPollBit;
        2: w[7] = 1'b1;
        default: w[7] = mCapErase ? 1'b0 : ~mCapPoll;
      endcase
      w[6] = mT6;
      w[5] = mFail;
      w[3] = (m == 1) && engIsErase && !eraseWindowOpen;
      w[2] = mT2;
      w[1] = mAbort;
    end
    return w;
  endfunction

  function automatic string tagOf();
    case (expMode())
      1: return engIsErase ? "R7" : "R2";
      2: return "R8";
      3: return "R5";
      4: return "R6";
      default: return "R1";
    endcase
  endfunction

  // one clock: advance model from pre-edge inputs, then land at negedge
  task automatic step();
    int m = expMode();
    bit fall = mOePrev && !oeN;
    bit nFail, nAbort;
    if (fall && (m == 1 || m == 3 || m == 4)) mT6 = ~mT6;
    if (fall && (m == 2 || (m == 1 && engIsErase && rdBlock == opBlock))) mT2 = ~mT2;
    if (engBusy && !mFail) begin
      mCapErase = engIsErase;
      mCapPoll  = progPollBit;
    end
    nFail  = engFail  || (mFail  && !cmdReadReset);
    nAbort = bufAbort || (mAbort && !cmdAbortReset);
    mFail = nFail; mAbort = nAbort;
    mOePrev = oeN;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag);
    logic [DATA_W-1:0] ew = expWord();
    logic ea = (expMode() != 0);
    nChecks++;
    if (statusWord !== ew || statusActive !== ea) begin
      nFails++;
      $display("FAIL %s: active=%0b word=%h expected active=%0b word=%h",
               tag, statusActive, statusWord, ea, ew);
    end
  endtask

  task automatic doRead(logic [BLK_W-1:0] blk, int lowCycles, string tag);
    rdBlock = blk;
    oeN = 1'b0;
    for (int i = 0; i < lowCycles; i++) begin
      step();
      check(tag);
    end
    oeN = 1'b1;
    step();
  endtask

  task automatic pulseFail();   engFail = 1;       step(); engFail = 0;       endtask
  task automatic pulseAbort();  bufAbort = 1;      step(); bufAbort = 0;      endtask
  task automatic pulseRdRst();  cmdReadReset = 1;  step(); cmdReadReset = 0;  endtask
  task automatic pulseAbRst();  cmdAbortReset = 1; step(); cmdAbortReset = 0; endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] w0;
    void'($urandom(32'd20240611));
    mOePrev = 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    // R12 reset state: inactive, zero word
    check("R12");

    // R2 program busy, both data polarities, bit6 per read (R4)
    engBusy = 1; engIsErase = 0; progPollBit = 1; step(); check("R2");
    doRead(7'd5, 1, "R2");
    progPollBit = 0; step(); check("R2");
    doRead(7'd1, 1, "R4");
    // R4: strobe held low 6 clocks counts once
    w0 = statusWord;
    doRead(7'd3, 6, "R4");
    // R10 completion
    engBusy = 0; #1; check("R10"); step(); check("R10");

    // R7/R3/R9 erase busy, window open then closed
    engBusy = 1; engIsErase = 1; eraseWindowOpen = 1; step(); check("R7");
    doRead(7'd1, 1, "R9");
    doRead(7'd4, 1, "R9");
    eraseWindowOpen = 0; step(); check("R7");
    doRead(7'd1, 2, "R3");

    // R8 suspend: hit toggles bit2, miss reads array
    engBusy = 0; engSuspended = 1; step();
    doRead(7'd2, 1, "R8");
    doRead(7'd2, 1, "R8");
    doRead(7'd6, 1, "R8");
    doRead(7'd2, 1, "R8");
    engSuspended = 0; step();

    // R5 failure persists after busy drops, cleared by read/reset
    engBusy = 1; engIsErase = 0; progPollBit = 1; step();
    pulseFail(); check("R5");
    engBusy = 0; progPollBit = 0; step(); check("R5");
    doRead(7'd9, 1, "R5");
    pulseRdRst(); check("R5");

    // R6 abort not cleared by read/reset, cleared by abort reset
    pulseAbort(); check("R6");
    pulseRdRst(); check("R6");
    doRead(7'd0, 1, "R6");
    pulseAbRst(); check("R6");

    // random mix
    for (int it = 0; it < 1500; it++) begin
      int op = $urandom_range(0, 11);
      case (op)
        0: begin engBusy = 1; engIsErase = 0; progPollBit = $urandom_range(0, 1); engSuspended = 0; end
        1: begin engBusy = 1; engIsErase = 1; eraseWindowOpen = $urandom_range(0, 1); engSuspended = 0; end
        2: begin engBusy = 0; engSuspended = 1; end
        3: begin engBusy = 0; engSuspended = 0; end
        4: if ($urandom_range(0, 3) == 0) pulseFail();
        5: if ($urandom_range(0, 3) == 0) pulseAbort();
        6: pulseRdRst();
        7: pulseAbRst();
        8: eraseWindowOpen = ~eraseWindowOpen;
        default: doRead(7'($urandom_range(0, 3)), $urandom_range(1, 3), tagOf());
      endcase
      step();
      check(tagOf());
      // R11 spare bits checked inside every compare
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule